// File: doc/BRIEF.md
# Partial-Bypass Operand Interlock

This block sits in the operand-read stage of a six-stage in-order pipeline (fetch, decode, operand-read, execute-1, execute-2, writeback). For each source operand of the instruction held in operand-read, it decides where the value comes from. The value can come from the register file, or from a forwarding path out of one of the later producer stages. If the value cannot be obtained legally in this cycle, the block raises a stall.

Forwarding paths only ever end at an operand-read port. Each producer-to-port path can be kept or removed at compile time. Removal is set through three parameter masks: one per producer stage, one per operand port, and one per individual path. The interlock must stall exactly when a needed path is missing.

Writeback updates the register file early in the cycle, so a read in the same cycle sees the new value. For this reason writeback is not a producer here. While stalled, the earlier stages hold their contents. The block owns the execute-1 valid flag and places a bubble there for every stalled cycle.

Top module: `bp_interlock`

## Requirements
- R1: An operand whose register matches no writing producer stage selects the register file (select code 0) and causes no stall.
- R2: When the youngest matching producer p has its result-valid flag set and the path from p to that operand is enabled, the operand selects code p+1 and causes no stall. Producer 0 is execute-1 and producer 1 is execute-2.
- R3: When several producers write the operand's register, only the youngest one (lowest index) is considered. If it cannot supply the value, the block stalls even when an older producer could.
- R4: A matching youngest producer whose result-valid flag is low causes a stall.
- R5: A matching youngest producer that is ready, but whose path to that operand is disabled, causes a stall. The operand's select is then code 0.
- R6: Register 0 never causes a bypass or a stall, either as a source or as a producer destination.
- R7: An operand with its use flag low never stalls. No stall is raised while operand-read holds no valid instruction.
- R8: Execute-1 valid is 0 in reset. After each clock edge it equals the operand-read valid flag ANDed with the inverse of stall from the previous cycle.
- R9: Stall is the OR over all operands of their individual stall needs. An operand that can be served keeps its select while another operand stalls.
- R10: Path (p,s) is enabled when bit p*NUM_SRC+s of PATH_MASK, bit p of SRC_MASK and bit s of DST_MASK are all 1. With the default masks, every path is enabled except execute-2 to operand 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| or_valid | input | 1 | Operand-read holds a valid instruction |
| src_use | input | NUM_SRC | Per operand: the operand is read |
| src_reg | input | NUM_SRC*REG_W | Per operand register number, operand s at bits s*REG_W |
| prod_wr | input | NUM_PROD | Per producer stage: holds an instruction that writes a register |
| prod_rd | input | NUM_PROD*REG_W | Per producer destination register, producer p at bits p*REG_W |
| prod_rdy | input | NUM_PROD | Per producer: result value is available in that stage |
| src_sel | output | NUM_SRC*SEL_W | Per operand select: 0 register file, p+1 producer p |
| stall | output | 1 | Hold fetch, decode and operand-read this cycle |
| ex1_valid | output | 1 | Valid flag of the execute-1 slot (0 means bubble) |

## Verification
The assertions check several rules on every cycle. A disabled path is never selected. Select codes stay in range. A stall never appears while operand-read is empty. Register 0 reads from the register file. The execute-1 valid flag follows the issue rule. The bench scenarios show the behaviours that depend on a specific hazard. These include the youngest-producer priority against an older ready producer, the stall for a result that is not yet valid, and the stall caused by the one removed path. They also include the dependent multiply-then-add case, where execute-1 forwards 10 to the add.

// File: rtl/bp_pkg.sv
package bp_pkg;

   // classification of one operand in operand-read
   typedef enum logic [1:0] {
      SRC_RF   = 2'd0,
      SRC_BYP  = 2'd1,
      SRC_WAIT = 2'd2
   } src_kind_e;

   function automatic int sel_width(input int nprod);
      return $clog2(nprod + 1);
   endfunction

endpackage

// File: rtl/bp_match.sv
// Compares one operand register against every producer destination.
module bp_match #(
   parameter int NUM_PROD = 2,
   parameter int REG_W    = 5
) (
   input  logic                       src_use,
   input  logic [REG_W-1:0]           src_reg,
   input  logic [NUM_PROD-1:0]        prod_wr,
   input  logic [NUM_PROD*REG_W-1:0]  prod_rd,
   output logic [NUM_PROD-1:0]        hit
);
   logic src_live;
   assign src_live = src_use && (src_reg != '0);

   for (genvar p = 0; p < NUM_PROD; p++) begin : g_cmp
      logic [REG_W-1:0] dst;
      assign dst    = prod_rd[p*REG_W +: REG_W];
      assign hit[p] = src_live && prod_wr[p] && (dst == src_reg);
   end
endmodule

// File: rtl/bp_operand.sv
// Picks the youngest matching producer and classifies the operand.
module bp_operand
   import bp_pkg::*;
#(
   parameter int NUM_PROD = 2,
   parameter int SEL_W    = 2
) (
   input  logic [NUM_PROD-1:0] hit,
   input  logic [NUM_PROD-1:0] prod_rdy,
   input  logic [NUM_PROD-1:0] path_en,
   output logic [SEL_W-1:0]    sel,
   output src_kind_e           kind
);
   logic             found;
   logic [SEL_W-1:0] first;
   logic             first_rdy;
   logic             first_en;

   always_comb begin
      found     = 1'b0;
      first     = '0;
      first_rdy = 1'b0;
      first_en  = 1'b0;
      for (int p = NUM_PROD - 1; p >= 0; p--) begin
         if (hit[p]) begin
            found     = 1'b1;
            first     = SEL_W'(p);
            first_rdy = prod_rdy[p];
            first_en  = path_en[p];
         end
      end
   end

   always_comb begin
      if (!found) begin
         kind = SRC_RF;
         sel  = '0;
      end else if (first_rdy && first_en) begin
         kind = SRC_BYP;
         sel  = first + SEL_W'(1);
      end else begin
         kind = SRC_WAIT;
         sel  = '0;
      end
   end
endmodule

// File: rtl/bp_issue.sv
// Combines operand waits into a stall and owns the execute-1 valid flag.
module bp_issue #(
   parameter int NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               or_valid,
   input  logic [NUM_SRC-1:0] need_wait,
   output logic               stall,
   output logic               ex1_valid
);
   assign stall = or_valid && (|need_wait);

   always_ff @(posedge clk) begin
      if (!rst_n) ex1_valid <= 1'b0;
      else        ex1_valid <= or_valid && !stall;
   end
endmodule

// File: rtl/bp_interlock.sv
module bp_interlock
   import bp_pkg::*;
#(
   parameter int                          NUM_PROD  = 2,
   parameter int                          NUM_SRC   = 2,
   parameter int                          REG_W     = 5,
   parameter logic [NUM_PROD-1:0]         SRC_MASK  = '1,
   parameter logic [NUM_SRC-1:0]          DST_MASK  = '1,
   parameter logic [NUM_PROD*NUM_SRC-1:0] PATH_MASK = 4'b0111,
   localparam int                         SEL_W     = sel_width(NUM_PROD)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       or_valid,
   input  logic [NUM_SRC-1:0]         src_use,
   input  logic [NUM_SRC*REG_W-1:0]   src_reg,
   input  logic [NUM_PROD-1:0]        prod_wr,
   input  logic [NUM_PROD*REG_W-1:0]  prod_rd,
   input  logic [NUM_PROD-1:0]        prod_rdy,
   output logic [NUM_SRC*SEL_W-1:0]   src_sel,
   output logic                       stall,
   output logic                       ex1_valid
);
   if (NUM_PROD < 1 || NUM_PROD > 7) begin : g_bad_prod
      $error("bp_interlock: NUM_PROD must be 1..7");
   end
   if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_src
      $error("bp_interlock: NUM_SRC must be 1..4");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("bp_interlock: REG_W must be at least 1");
   end

   logic [NUM_SRC-1:0] need_wait;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [NUM_PROD-1:0] hit;
      logic [NUM_PROD-1:0] path_en;
      src_kind_e           kind;

      for (genvar p = 0; p < NUM_PROD; p++) begin : g_path
         localparam logic EN = PATH_MASK[p*NUM_SRC+s] & SRC_MASK[p] & DST_MASK[s];
         assign path_en[p] = EN;
      end

      bp_match #(.NUM_PROD(NUM_PROD), .REG_W(REG_W)) u_match (
         .src_use (src_use[s]),
         .src_reg (src_reg[s*REG_W +: REG_W]),
         .prod_wr (prod_wr),
         .prod_rd (prod_rd),
         .hit     (hit)
      );

      bp_operand #(.NUM_PROD(NUM_PROD), .SEL_W(SEL_W)) u_opnd (
         .hit      (hit),
         .prod_rdy (prod_rdy),
         .path_en  (path_en),
         .sel      (src_sel[s*SEL_W +: SEL_W]),
         .kind     (kind)
      );

      assign need_wait[s] = (kind == SRC_WAIT);
   end

   bp_issue #(.NUM_SRC(NUM_SRC)) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .or_valid  (or_valid),
      .need_wait (need_wait),
      .stall     (stall),
      .ex1_valid (ex1_valid)
   );
endmodule

// File: rtl/bp_interlock_chk.sv
module bp_interlock_chk #(
   parameter int                          NUM_PROD  = 2,
   parameter int                          NUM_SRC   = 2,
   parameter int                          REG_W     = 5,
   parameter logic [NUM_PROD-1:0]         SRC_MASK  = '1,
   parameter logic [NUM_SRC-1:0]          DST_MASK  = '1,
   parameter logic [NUM_PROD*NUM_SRC-1:0] PATH_MASK = '1,
   parameter int                          SEL_W     = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       or_valid,
   input logic [NUM_SRC-1:0]         src_use,
   input logic [NUM_SRC*REG_W-1:0]   src_reg,
   input logic [NUM_SRC*SEL_W-1:0]   src_sel,
   input logic                       stall,
   input logic                       ex1_valid
);
   // R7: empty operand-read never stalls
   assert_idle_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !or_valid |-> !stall);

   // R8: a stalled cycle puts a bubble into execute-1
   assert_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !ex1_valid);

   // R8: an unstalled valid instruction issues
   assert_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (or_valid && !stall) |=> ex1_valid);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
      // R2: select code never exceeds the producer count
      assert_sel_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
         src_sel[s*SEL_W +: SEL_W] <= SEL_W'(NUM_PROD));

      // R6: register 0 always reads the register file
      assert_reg0_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (src_reg[s*REG_W +: REG_W] == '0) |-> (src_sel[s*SEL_W +: SEL_W] == '0));

      // R7: an unused operand selects the register file
      assert_unused_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !src_use[s] |-> (src_sel[s*SEL_W +: SEL_W] == '0));

      for (genvar p = 0; p < NUM_PROD; p++) begin : g_p
         localparam logic EN = PATH_MASK[p*NUM_SRC+s] & SRC_MASK[p] & DST_MASK[s];
         if (!EN) begin : g_off
            // R5 / R10: a removed path is never selected
            assert_no_absent_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
               src_sel[s*SEL_W +: SEL_W] != SEL_W'(p + 1));
         end
      end
   end
endmodule

bind bp_interlock bp_interlock_chk #(
   .NUM_PROD  (NUM_PROD),
   .NUM_SRC   (NUM_SRC),
   .REG_W     (REG_W),
   .SRC_MASK  (SRC_MASK),
   .DST_MASK  (DST_MASK),
   .PATH_MASK (PATH_MASK),
   .SEL_W     (SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .or_valid  (or_valid),
   .src_use   (src_use),
   .src_reg   (src_reg),
   .src_sel   (src_sel),
   .stall     (stall),
   .ex1_valid (ex1_valid)
);

// File: tb/tb_bp_interlock.sv
module tb_bp_interlock;
   localparam int NP = 2;
   localparam int NS = 2;
   localparam int RW = 5;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          or_valid = 1'b0;
   logic [NS-1:0] src_use = '0;
   logic [NS*RW-1:0] src_reg = '0;
   logic [NP-1:0] prod_wr = '0;
   logic [NP*RW-1:0] prod_rd = '0;
   logic [NP-1:0] prod_rdy = '0;
   logic [NS*SW-1:0] src_sel;
   logic          stall;
   logic          ex1_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   bp_interlock dut (
      .clk(clk), .rst_n(rst_n), .or_valid(or_valid), .src_use(src_use),
      .src_reg(src_reg), .prod_wr(prod_wr), .prod_rd(prod_rd),
      .prod_rdy(prod_rdy), .src_sel(src_sel), .stall(stall),
      .ex1_valid(ex1_valid)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_prod(input int p, input bit wr, input int rd, input bit rdy);
      prod_wr[p] = wr;
      prod_rd[p*RW +: RW] = RW'(rd);
      prod_rdy[p] = rdy;
   endtask

   task automatic set_src(input int s, input bit use_it, input int r);
      src_use[s] = use_it;
      src_reg[s*RW +: RW] = RW'(r);
   endtask

   task automatic clear_all();
      prod_wr = '0; prod_rd = '0; prod_rdy = '0;
      src_use = '0; src_reg = '0; or_valid = 1'b1;
   endtask

   function automatic int sel_of(input int s);
      return int'(src_sel[s*SW +: SW]);
   endfunction

   // inputs change at negedge, outputs are sampled 5 ns later
   task automatic settle();
      @(negedge clk);
      #5;
   endtask

   task automatic t_reset();
      chk("R8 reset ex1_valid", int'(ex1_valid), 0);
   endtask

   task automatic t_no_dep();
      @(negedge clk); clear_all();
      set_prod(0, 1, 1, 1); set_prod(1, 1, 4, 1);
      set_src(0, 1, 2); set_src(1, 1, 3);
      #5;
      chk("R1 sel0", sel_of(0), 0);
      chk("R1 sel1", sel_of(1), 0);
      chk("R1 stall", int'(stall), 0);
   endtask

   task automatic t_mul_add();
      // multiply into R1 in execute-1, add reads R1 and R3
      @(negedge clk); clear_all();
      set_prod(0, 1, 1, 1);
      set_src(0, 1, 1); set_src(1, 1, 3);
      #5;
      chk("R2 ex1 forward sel0", sel_of(0), 1);
      chk("R2 R3 from rf sel1", sel_of(1), 0);
      chk("R2 no stall", int'(stall), 0);
      chk("R2 forwarded sum", (sel_of(0) == 1 ? 2 * 5 : 0) + 5, 15);
      @(negedge clk); clear_all();
      set_prod(1, 1, 9, 1);
      set_src(0, 1, 9);
      #5;
      chk("R2 ex2 forward sel0", sel_of(0), 2);
      chk("R2 ex2 no stall", int'(stall), 0);
   endtask

   task automatic t_priority();
      @(negedge clk); clear_all();
      set_prod(0, 1, 4, 1); set_prod(1, 1, 4, 1);
      set_src(0, 1, 4);
      #5;
      chk("R3 youngest wins", sel_of(0), 1);
      chk("R3 no stall", int'(stall), 0);
      @(negedge clk);
      set_prod(0, 1, 4, 0);
      #5;
      chk("R3 young not ready stalls", int'(stall), 1);
      chk("R3 older not used", sel_of(0), 0);
   endtask

   task automatic t_not_ready();
      @(negedge clk); clear_all();
      set_prod(1, 1, 7, 0);
      set_src(0, 1, 7);
      #5;
      chk("R4 not ready stall", int'(stall), 1);
   endtask

   task automatic t_path_absent();
      @(negedge clk); clear_all();
      set_prod(1, 1, 6, 1);
      set_src(1, 1, 6);
      #5;
      chk("R5 ex2->op1 absent stall", int'(stall), 1);
      chk("R5 sel1 zero", sel_of(1), 0);
      @(negedge clk); clear_all();
      set_prod(0, 1, 6, 1);
      set_src(1, 1, 6);
      #5;
      chk("R10 ex1->op1 present", sel_of(1), 1);
      chk("R10 ex1->op1 no stall", int'(stall), 0);
   endtask

   task automatic t_reg0();
      @(negedge clk); clear_all();
      set_prod(0, 1, 0, 0); set_prod(1, 1, 0, 1);
      set_src(0, 1, 0); set_src(1, 1, 0);
      #5;
      chk("R6 reg0 stall", int'(stall), 0);
      chk("R6 reg0 sel0", sel_of(0), 0);
      chk("R6 reg0 sel1", sel_of(1), 0);
   endtask

   task automatic t_unused();
      @(negedge clk); clear_all();
      set_prod(0, 1, 8, 0);
      set_src(0, 0, 8);
      #5;
      chk("R7 unused no stall", int'(stall), 0);
      @(negedge clk);
      set_src(0, 1, 8);
      or_valid = 1'b0;
      #5;
      chk("R7 empty no stall", int'(stall), 0);
   endtask

   task automatic t_mixed();
      @(negedge clk); clear_all();
      set_prod(0, 1, 2, 1); set_prod(1, 1, 3, 0);
      set_src(0, 1, 2); set_src(1, 1, 3);
      #5;
      chk("R9 one waits -> stall", int'(stall), 1);
      chk("R9 other keeps sel", sel_of(0), 1);
   endtask

   task automatic t_bubble();
      @(negedge clk); clear_all();
      set_prod(0, 1, 5, 0);
      set_src(0, 1, 5);
      @(posedge clk); #5;
      chk("R8 bubble after stall", int'(ex1_valid), 0);
      @(negedge clk);
      set_prod(0, 1, 5, 1);
      @(posedge clk); #5;
      chk("R8 issue after release", int'(ex1_valid), 1);
      @(negedge clk);
      or_valid = 1'b0;
      @(posedge clk); #5;
      chk("R8 empty issues bubble", int'(ex1_valid), 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #5;
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_no_dep();
      t_mul_add();
      t_priority();
      t_not_ready();
      t_path_absent();
      t_reg0();
      t_unused();
      t_mixed();
      t_bubble();
      settle();
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end
endmodule